// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command interpreter and write sequencer of a byte-wide NOR-style parallel flash. It sits behind a simple synchronous bus with an address, a write strobe carrying a data byte, a read strobe and a registered read data byte. Bytes written while the sequencer is idle are read as command codes, whatever the address. Some codes start multi-cycle sequences that expect a data word or a confirm code in a later write. Program, sector erase, block lock and buffered write sequences all end by setting the ready bit of an 8-bit status register. An error in a sequence drops the block back to plain array reads.

The last accepted command picks what a read returns: array contents, the status byte, a two-byte identifier or a small query table. The storage is an internal array whose size is the sector size times the sector count. A write-protect input blocks all changes to the array and sets error bits in the status byte instead. Program and erase complete in the same clock, so the ready bit never drops.

Top module: `pflash_cmd_fsm`

## Requirements
- R1: After reset the read data is 0x00, the status byte is 0x80 (bit 7 = ready), the sequencer is idle and reads return array data; every array byte reads 0xFF.
- R2: An idle write of 0x10 or 0x40 arms a program. The next write stores its byte at its address, sets status bit 7 and returns the sequencer to idle.
- R3: An idle write of 0x20 fills the sector holding the address with 0xFF. The sector is found by clearing the low log2(sector size) address bits. The next write must be 0xD0 (confirm, status stays readable) or 0xFF (array read). Any other byte returns the block to idle array read.
- R4: With write-protect high, an erase leaves the array unchanged and sets status bits 5 and 7. A program leaves the array unchanged and sets status bits 4 and 7.
- R5: An idle write of 0x50 clears all eight status bits and selects array read.
- R6: An idle write of 0x60 arms a lock sequence. A second write of 0xD0 or 0x01 sets status bit 7 and ends it. Any other second byte returns to idle array read.
- R7: Idle writes of 0x70 and 0x90 select status read and identifier read without starting a sequence. In identifier read, address 0 returns the maker code and address 1 the device code; other addresses return 0x00. Idle writes of 0x00, 0xF0 and 0xFF select array read.
- R8: While the last command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte.
- R9: An idle write of any other code returns the sequencer to idle and selects array read.
- R10: An idle write of 0xE8 sets status bit 7. The next write gives a count N. The next N+1 writes store their bytes at their addresses. A following 0xD0 ends the sequence with status readable, and any other byte returns to array read; the stored bytes stay.
- R11: An idle write of 0x98 selects query read. Address 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Address 0x27 returns log2 of the array size in bytes. Address 0x2C returns 0x01, and others return 0x00. Only a write of 0xFF leaves query mode.
- R12: Read data appears in the cycle after the read strobe and holds while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp | input | 1 | Write protect for the array |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_data | input | 8 | Command, confirm, count or data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The embedded properties check, on every cycle, the single-step transitions. These are the return to idle after a program, lock or unknown code, the status clear, and the mode selects that do not start a sequence. They also check that an erase fills the sector base with 0xFF, that a protected erase sets its error bits, and that a status-mode read returns the status byte. What an erase, program or buffered write does to the array as a whole can only be seen through the bench's scenarios. The same holds for sector confinement, identifier and query contents, abort paths and the read-hold behaviour, which need sequences of writes followed by array reads.

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm #(
  parameter int SECTOR_BYTES = 16,
  parameter int NUM_SECTORS  = 4,
  parameter logic [7:0] MAKER_CODE  = 8'h5A,
  parameter logic [7:0] DEVICE_CODE = 8'hC3,
  localparam int ARRAY_BYTES = SECTOR_BYTES * NUM_SECTORS,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES),
  localparam int SEC_W       = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);

  localparam logic [7:0] C_ARRAY  = 8'h00;
  localparam logic [7:0] C_PROG_A = 8'h10;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_ERASE2 = 8'h28;
  localparam logic [7:0] C_PROG_B = 8'h40;
  localparam logic [7:0] C_CLRST  = 8'h50;
  localparam logic [7:0] C_LOCK   = 8'h60;
  localparam logic [7:0] C_STATUS = 8'h70;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_BUFWR  = 8'hE8;
  localparam logic [7:0] C_ALTRST = 8'hF0;
  localparam logic [7:0] C_RESET  = 8'hFF;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_LOCK2  = 8'h01;

  localparam int ST_READY = 7;
  localparam int ST_ERERR = 5;
  localparam int ST_PRERR = 4;

  logic [7:0]        mem [ARRAY_BYTES];
  logic [7:0]        status;
  logic [7:0]        cmd;
  logic [1:0]        cyc;
  logic [ADDR_W-1:0] cnt;
  logic [7:0]        rd_mux;
  logic [15:0]       addr16;
  logic [ADDR_W-1:0] sec_base;

  assign addr16   = 16'(addr);
  assign sec_base = {addr[ADDR_W-1:SEC_W], SEC_W'(0)};

  function automatic logic shows_status(input logic [7:0] c);
    return c == C_PROG_A || c == C_ERASE || c == C_ERASE2 || c == C_PROG_B ||
           c == C_CLRST  || c == C_LOCK  || c == C_STATUS || c == C_BUFWR;
  endfunction

  function automatic logic known_first(input logic [7:0] c);
    return c == C_ARRAY || c == C_PROG_A || c == C_ERASE || c == C_PROG_B ||
           c == C_CLRST || c == C_LOCK   || c == C_STATUS || c == C_IDENT ||
           c == C_QUERY || c == C_BUFWR  || c == C_ALTRST || c == C_RESET;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 8'h80;
      cmd    <= C_ARRAY;
      cyc    <= 2'd0;
      cnt    <= '0;
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      case (cyc)
        2'd0: begin
          case (wr_data)
            C_PROG_A, C_PROG_B, C_LOCK, C_QUERY: begin
              cmd <= wr_data;
              cyc <= 2'd1;
            end
            C_ERASE: begin
              if (wp) status <= status | 8'hA0;
              else begin
                status[ST_READY] <= 1'b1;
                for (int i = 0; i < ARRAY_BYTES; i++)
                  if ((i / SECTOR_BYTES) == int'(addr >> SEC_W)) mem[i] <= 8'hFF;
              end
              cmd <= wr_data;
              cyc <= 2'd1;
            end
            C_BUFWR: begin
              status[ST_READY] <= 1'b1;
              cmd <= wr_data;
              cyc <= 2'd1;
            end
            C_CLRST: begin
              status <= 8'h00;
              cmd    <= C_ARRAY;
            end
            C_STATUS, C_IDENT: cmd <= wr_data;
            default: cmd <= C_ARRAY;
          endcase
        end
        2'd1: begin
          case (cmd)
            C_PROG_A, C_PROG_B: begin
              if (wp) status[ST_PRERR] <= 1'b1;
              else mem[addr] <= wr_data;
              status[ST_READY] <= 1'b1;
              cyc <= 2'd0;
            end
            C_ERASE: begin
              cyc <= 2'd0;
              if (wr_data == C_CONF) status[ST_READY] <= 1'b1;
              else cmd <= C_ARRAY;
            end
            C_LOCK: begin
              cyc <= 2'd0;
              if (wr_data == C_CONF || wr_data == C_LOCK2) status[ST_READY] <= 1'b1;
              else cmd <= C_ARRAY;
            end
            C_QUERY: begin
              if (wr_data == C_RESET) begin
                cmd <= C_ARRAY;
                cyc <= 2'd0;
              end
            end
            C_BUFWR: begin
              cnt <= ADDR_W'(wr_data);
              cyc <= 2'd2;
            end
            default: begin
              cmd <= C_ARRAY;
              cyc <= 2'd0;
            end
          endcase
        end
        2'd2: begin
          if (wp) status[ST_PRERR] <= 1'b1;
          else mem[addr] <= wr_data;
          status[ST_READY] <= 1'b1;
          if (cnt == '0) cyc <= 2'd3;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          cyc <= 2'd0;
          if (wr_data == C_CONF) status[ST_READY] <= 1'b1;
          else cmd <= C_ARRAY;
        end
      endcase
    end
  end

  always_comb begin
    if (shows_status(cmd)) rd_mux = status;
    else if (cmd == C_IDENT)
      rd_mux = (addr16 == 16'd0) ? MAKER_CODE : (addr16 == 16'd1) ? DEVICE_CODE : 8'h00;
    else if (cmd == C_QUERY) begin
      case (addr16)
        16'h0010: rd_mux = 8'h51;
        16'h0011: rd_mux = 8'h52;
        16'h0012: rd_mux = 8'h59;
        16'h0027: rd_mux = 8'(ADDR_W);
        16'h002C: rd_mux = 8'h01;
        default:  rd_mux = 8'h00;
      endcase
    end else rd_mux = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_PROG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd1 && (cmd == C_PROG_A || cmd == C_PROG_B)) |=> (cyc == 2'd0 && status[ST_READY])); // R2
  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wr_data == C_ERASE && !wp) |=> mem[$past(sec_base)] == 8'hFF); // R3
  AST_WP_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wr_data == C_ERASE && wp) |=> (status[ST_ERERR] && status[ST_READY])); // R4
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && wr_data == C_CLRST) |=> (status == 8'h00 && cmd == C_ARRAY)); // R5
  AST_LOCK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd1 && cmd == C_LOCK) |=> cyc == 2'd0); // R6
  AST_MODE_NO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && (wr_data == C_STATUS || wr_data == C_IDENT)) |=> (cyc == 2'd0 && cmd == $past(wr_data))); // R7
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && cmd == C_STATUS) |=> rd_data == $past(status)); // R8
  AST_UNKNOWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc == 2'd0 && !known_first(wr_data)) |=> (cyc == 2'd0 && cmd == C_ARRAY)); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R12

endmodule

// File: tb/pflash_cmd_fsm_bench.sv
module pflash_cmd_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_cmd_fsm u_pflash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .wp(wp), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (sb.size() == 0) chk(rd_data, 8'hxx, "scoreboard empty");
        else begin
          it = sb.pop_front();
          chk(rd_data, it.exp, it.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(rd_data, 8'h00, "R1 read data in reset");
    rst_n = 1'b1;
    rd(6'd5, 8'hFF, "R1 erased array after reset");
    wr(6'd0, 8'h70);
    rd(6'd0, 8'h80, "R1 ready status after reset");
    // program
    wr(6'd0, 8'hFF);
    wr(6'd3, 8'h40);
    wr(6'd3, 8'hA5);
    rd(6'd3, 8'h80, "R8 status after program");
    wr(6'd0, 8'hFF);
    rd(6'd3, 8'hA5, "R2 program via 0x40");
    wr(6'h14, 8'h10);
    wr(6'h14, 8'h3C);
    wr(6'd0, 8'hFF);
    rd(6'h14, 8'h3C, "R2 program via 0x10");
    wr(6'h17, 8'h10);
    wr(6'h17, 8'h11);
    // erase with confirm
    wr(6'h1A, 8'h20);
    wr(6'h1A, 8'hD0);
    rd(6'h1A, 8'h80, "R8 status after erase confirm");
    wr(6'd0, 8'hFF);
    rd(6'h14, 8'hFF, "R3 sector byte erased");
    rd(6'h17, 8'hFF, "R3 sector byte erased");
    rd(6'd3, 8'hA5, "R3 other sector kept");
    // erase abort and error
    wr(6'h22, 8'h40);
    wr(6'h22, 8'h55);
    wr(6'h22, 8'h20);
    wr(6'h22, 8'hFF);
    rd(6'h22, 8'hFF, "R3 abort to array read");
    wr(6'h30, 8'h20);
    wr(6'h30, 8'h77);
    rd(6'h30, 8'hFF, "R3 bad confirm returns to array");
    // write protect
    wp = 1'b1;
    wr(6'd5, 8'h40);
    wr(6'd5, 8'h12);
    rd(6'd5, 8'h90, "R4 program error bit");
    wr(6'd0, 8'h50);
    rd(6'd5, 8'hFF, "R4 protected byte unchanged");
    wr(6'd0, 8'h70);
    rd(6'd0, 8'h00, "R5 status cleared");
    wr(6'd3, 8'h20);
    rd(6'd3, 8'hA0, "R4 erase error bit");
    wr(6'd3, 8'hD0);
    wr(6'd0, 8'hFF);
    rd(6'd3, 8'hA5, "R4 protected sector unchanged");
    wp = 1'b0;
    // lock
    wr(6'd0, 8'h50);
    wr(6'd0, 8'h60);
    rd(6'd0, 8'h00, "R8 status during lock");
    wr(6'd0, 8'h01);
    rd(6'd0, 8'h80, "R6 lock sets ready");
    wr(6'd0, 8'h60);
    wr(6'd0, 8'h33);
    rd(6'd3, 8'hA5, "R6 bad lock code to array");
    // identifier
    wr(6'd0, 8'h90);
    rd(6'd0, 8'h5A, "R7 maker code");
    rd(6'd1, 8'hC3, "R7 device code");
    rd(6'd2, 8'h00, "R7 other id address");
    wr(6'd0, 8'hF0);
    rd(6'd3, 8'hA5, "R7 0xF0 to array");
    wr(6'd0, 8'h90);
    wr(6'd0, 8'h00);
    rd(6'd3, 8'hA5, "R7 0x00 to array");
    // query
    wr(6'd0, 8'h98);
    rd(6'h10, 8'h51, "R11 query Q");
    rd(6'h11, 8'h52, "R11 query R");
    rd(6'h12, 8'h59, "R11 query Y");
    rd(6'h27, 8'h06, "R11 query size");
    rd(6'h05, 8'h00, "R11 query blank");
    wr(6'd0, 8'h42);
    rd(6'h11, 8'h52, "R11 stays in query");
    wr(6'd0, 8'hFF);
    rd(6'd3, 8'hA5, "R11 leave query");
    // unknown
    wr(6'd0, 8'h70);
    wr(6'd0, 8'h33);
    rd(6'd3, 8'hA5, "R9 unknown code to array");
    // buffered write
    wr(6'h30, 8'hE8);
    wr(6'h30, 8'h02);
    wr(6'h30, 8'h01);
    wr(6'h31, 8'h02);
    wr(6'h32, 8'h03);
    rd(6'h30, 8'h80, "R10 status during buffer");
    wr(6'h30, 8'hD0);
    wr(6'd0, 8'hFF);
    rd(6'h30, 8'h01, "R10 buffer word 0");
    rd(6'h31, 8'h02, "R10 buffer word 1");
    rd(6'h32, 8'h03, "R10 buffer word 2");
    wr(6'h38, 8'hE8);
    wr(6'h38, 8'h00);
    wr(6'h38, 8'h44);
    wr(6'h38, 8'h99);
    rd(6'h38, 8'h44, "R10 abort keeps data in array mode");
    // hold
    rd(6'd3, 8'hA5, "R12 read latency");
    repeat (3) @(negedge clk);
    chk(rd_data, 8'hA5, "R12 read data held");
    repeat (2) @(negedge clk);
    chk(8'(sb.size()), 8'h00, "scoreboard drained");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule